// File: doc/BRIEF.md
# Antiphase Triangle Dither Injector for Paired DAC Channels

This block takes a stream of signed DAC codes and produces two code streams for two DAC channels whose analog outputs are summed off-chip. A large periodic triangle-wave dither is added to the first channel and subtracted from the second. In the analog sum the dither cancels. The conversion error caused by element mismatch is averaged, because each channel sweeps across many of its own levels every dither period. The input is halved before the dither is applied, so that half of the code range is left free for the dither swing.

The triangle is built from a bounded up/down level counter that runs between -Q and +Q, where Q is a quarter of the dither period. The counter moves one level for each accepted sample. The dither value is that level multiplied by a per-sample step setting, so the peak amplitude is Q times the step. With the default period of 20 samples, a 1 MS/s stream gets a 50 kHz dither fundamental. When the enable is low, both channels carry the input code unchanged and the triangle returns to its starting point. The outputs are registered, and both channels are clamped to the signed code range.

Top module: `antiphase_dither_top`

## Requirements
- R1: After reset, `out_valid` is 0 and both channel codes are 0. `out_valid` equals `in_valid` delayed by exactly one clock, and each accepted sample appears on the outputs one clock after it is accepted.
- R2: If `dith_en` is 0 when a sample is accepted, both `ch_a_code` and `ch_b_code` equal `in_code` exactly.
- R3: If `dith_en` is 1 when a sample is accepted, let h = `in_code` arithmetically shifted right by one bit (rounding toward minus infinity) and let d be the current dither value. Then `ch_a_code` = h + d and `ch_b_code` = h - d, each clamped as in R7.
- R4: d = L * `amp_step`, where L is a signed level. L is 0 for the first dithered sample and rises by 1 per sample up to +Q = PERIOD/4. It then falls by 1 per sample to -Q and rises again. With PERIOD = 20 the sequence is 0,1,2,3,4,5,4,...,-5,-4,...,-1 and repeats exactly every 20 samples.
- R5: The level advances only on accepted samples (`in_valid` = 1). While `in_valid` is 0, the channel codes hold their values and the dither phase does not move.
- R6: While Q * `amp_step` <= 2^(CODE_W-2), no clamping occurs, and `ch_a_code` + `ch_b_code` = 2h for every dithered sample.
- R7: Each channel result is clamped to the range from -2^(CODE_W-1) to 2^(CODE_W-1)-1.
- R8: A clock cycle with `dith_en` = 0 returns the level to 0 with the upward direction. The first dithered sample after re-enabling therefore has d = 0 and the sequence of R4 starts over.
- R9: `amp_step` is read with each accepted sample, so a new step value scales the very next sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input sample present this cycle |
| in_code | input | CODE_W | Signed input code |
| dith_en | input | 1 | 1 = inject dither, 0 = pass input through and clear phase |
| amp_step | input | STEP_W | Unsigned dither step per sample (peak = Q * step) |
| out_valid | output | 1 | Output samples present |
| ch_a_code | output | CODE_W | Signed code for channel A (half input plus dither) |
| ch_b_code | output | CODE_W | Signed code for channel B (half input minus dither) |

## Verification
The sum assertion assumes that the step setting keeps the peak dither within a quarter of the code range. The random stimulus draws steps only below 2^(CODE_W-2)/Q, so the assertion applies to every random sample. The deliberately oversized steps used to exercise clamping fall outside that condition. Input codes, enable toggles and gaps in `in_valid` are otherwise unconstrained. Directed runs with a constant input confirm the 20-sample repetition, hold the phase across invalid cycles, and restart the phase after the enable is dropped.

// File: rtl/dither_pkg.sv
// Shared types for the antiphase dither injector.
package dither_pkg;
    // Direction of the triangle level counter.
    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } tri_dir_e;
endpackage

// File: rtl/tri_level_gen.sv
// Triangle level generator.
// What it does: holds a signed level in [-QUARTER, +QUARTER]. The level moves
// one step per advance pulse and turns back at each bound, so a full
// up/down cycle lasts 4*QUARTER advances.
// What it assumes: clear has priority over advance; QUARTER >= 1.
module tri_level_gen
    import dither_pkg::*;
#(
    parameter int QUARTER = 5,
    parameter int LVL_W   = $clog2(QUARTER + 1) + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    advance,
    output logic signed [LVL_W-1:0] level
);
    localparam logic signed [LVL_W-1:0] TOP = LVL_W'(QUARTER);
    localparam logic signed [LVL_W-1:0] BOT = -LVL_W'(QUARTER);

    tri_dir_e                dir_q;
    logic signed [LVL_W-1:0] nxt_level;

    // Purpose: compute the next level from the current direction.
    always_comb begin
        nxt_level = (dir_q == DIR_UP) ? level + LVL_W'(1) : level - LVL_W'(1);
    end

    // Purpose: update the level and turn the direction at the bounds.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            level <= '0;
            dir_q <= DIR_UP;
        end else if (advance) begin
            level <= nxt_level;
            if (nxt_level == TOP) begin
                dir_q <= DIR_DOWN;
            end else if (nxt_level == BOT) begin
                dir_q <= DIR_UP;
            end
        end
    end
endmodule

// File: rtl/dither_lane.sv
// One output lane: half-scale input plus or minus the dither, clamped.
// What it does: forms base +/- dither at full precision and clamps the result
// to the signed CODE_W range.
// What it assumes: EXT_W is wide enough to hold the unclamped sum exactly.
module dither_lane #(
    parameter int CODE_W = 16,
    parameter int PROD_W = 20,
    parameter bit NEGATE = 1'b0,
    parameter int EXT_W  = CODE_W + PROD_W + 1
) (
    input  logic signed [CODE_W-1:0] base,
    input  logic signed [PROD_W-1:0] dither,
    output logic signed [CODE_W-1:0] code
);
    localparam logic signed [EXT_W-1:0] MAX_C = EXT_W'((2 ** (CODE_W - 1)) - 1);
    localparam logic signed [EXT_W-1:0] MIN_C = -EXT_W'(2 ** (CODE_W - 1));

    logic signed [EXT_W-1:0] raw;

    // Purpose: apply the dither with this lane's polarity, then clamp.
    always_comb begin
        if (NEGATE) begin
            raw = EXT_W'(base) - EXT_W'(dither);
        end else begin
            raw = EXT_W'(base) + EXT_W'(dither);
        end
        if (raw > MAX_C) begin
            code = MAX_C[CODE_W-1:0];
        end else if (raw < MIN_C) begin
            code = MIN_C[CODE_W-1:0];
        end else begin
            code = raw[CODE_W-1:0];
        end
    end
endmodule

// File: rtl/antiphase_dither_top.sv
// Antiphase triangle dither injector for two summed DAC channels.
// What it does: with dither enabled, it halves each input code and drives
// half+d on lane A and half-d on lane B, where d is a triangle of period
// PERIOD samples. With dither disabled, it passes the input to both lanes.
// Outputs are registered with one cycle of latency.
// What it assumes: PERIOD is a multiple of 4; codes are two's complement.
module antiphase_dither_top #(
    parameter int CODE_W = 16,
    parameter int STEP_W = 14,
    parameter int PERIOD = 20
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [CODE_W-1:0] in_code,
    input  logic                     dith_en,
    input  logic        [STEP_W-1:0] amp_step,
    output logic                     out_valid,
    output logic signed [CODE_W-1:0] ch_a_code,
    output logic signed [CODE_W-1:0] ch_b_code
);
    localparam int QUARTER = PERIOD / 4;
    localparam int LVL_W   = $clog2(QUARTER + 1) + 1;
    localparam int PROD_W  = LVL_W + STEP_W + 1;
    localparam int LANES   = 2;

    logic signed [LVL_W-1:0]  level;
    logic signed [PROD_W-1:0] dither;
    logic signed [CODE_W-1:0] half_code;
    logic signed [CODE_W-1:0] lane_code [LANES];

    tri_level_gen #(
        .QUARTER(QUARTER),
        .LVL_W  (LVL_W)
    ) level_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (!dith_en),
        .advance(in_valid),
        .level  (level)
    );

    // Purpose: scale the input to half range and form the dither value.
    always_comb begin
        half_code = in_code >>> 1;
        dither    = PROD_W'(level) * PROD_W'({1'b0, amp_step});
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        dither_lane #(
            .CODE_W(CODE_W),
            .PROD_W(PROD_W),
            .NEGATE(g == 1)
        ) lane_i (
            .base  (half_code),
            .dither(dither),
            .code  (lane_code[g])
        );
    end

    // Purpose: register the lane codes, or the bypassed input, with valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            ch_a_code <= '0;
            ch_b_code <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                ch_a_code <= dith_en ? lane_code[0] : in_code;
                ch_b_code <= dith_en ? lane_code[1] : in_code;
            end
        end
    end
endmodule

// File: rtl/antiphase_dither_chk.sv
// Checker for antiphase_dither_top; attached by the bind below.
// What it does: records the previous cycle's inputs and relates them to the
// outputs. What it assumes: the sum check applies only while the peak
// dither stays within a quarter of the code range.
module antiphase_dither_chk #(
    parameter int CODE_W = 16,
    parameter int STEP_W = 14,
    parameter int PERIOD = 20
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     in_valid,
    input logic signed [CODE_W-1:0] in_code,
    input logic                     dith_en,
    input logic        [STEP_W-1:0] amp_step,
    input logic                     out_valid,
    input logic signed [CODE_W-1:0] ch_a_code,
    input logic signed [CODE_W-1:0] ch_b_code
);
    localparam int QUARTER = PERIOD / 4;
    localparam int W2      = CODE_W + STEP_W + 8;
    localparam logic [W2-1:0] PEAK_LIM = W2'(2 ** (CODE_W - 2));

    logic                     past_ok;
    logic                     p_valid;
    logic                     p_en;
    logic signed [CODE_W-1:0] p_code;
    logic        [W2-1:0]     p_peak;
    logic signed [W2-1:0]     sum_ab;
    logic signed [W2-1:0]     diff_ab;
    logic signed [W2-1:0]     p_half2;

    // Purpose: capture last cycle's inputs for comparison with the outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            past_ok <= 1'b0;
            p_valid <= 1'b0;
            p_en    <= 1'b0;
            p_code  <= '0;
            p_peak  <= '0;
        end else begin
            past_ok <= 1'b1;
            p_valid <= in_valid;
            p_en    <= dith_en;
            p_code  <= in_code;
            p_peak  <= W2'(amp_step) * W2'(QUARTER);
        end
    end

    // Purpose: form the lane sum, lane difference and expected sum.
    always_comb begin
        sum_ab  = W2'(ch_a_code) + W2'(ch_b_code);
        diff_ab = W2'(ch_a_code) - W2'(ch_b_code);
        p_half2 = W2'(p_code >>> 1) * W2'(2);
    end

    // R1
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (out_valid == p_valid));

    // R2
    bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && p_valid && !p_en) |-> (ch_a_code == p_code && ch_b_code == p_code));

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && p_valid && p_en && p_peak <= PEAK_LIM) |-> (sum_ab == p_half2));

    // R3
    spread_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && p_valid && p_en) |->
            (diff_ab <= W2'(2) * $signed(p_peak) && diff_ab >= -(W2'(2) * $signed(p_peak))));

    // R5
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !p_valid) |-> ($stable(ch_a_code) && $stable(ch_b_code)));
endmodule

bind antiphase_dither_top antiphase_dither_chk #(
    .CODE_W(CODE_W),
    .STEP_W(STEP_W),
    .PERIOD(PERIOD)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_code  (in_code),
    .dith_en  (dith_en),
    .amp_step (amp_step),
    .out_valid(out_valid),
    .ch_a_code(ch_a_code),
    .ch_b_code(ch_b_code)
);

// File: tb/antiphase_dither_top_tb.sv
module antiphase_dither_top_tb_top;
    localparam int CODE_W  = 16;
    localparam int STEP_W  = 14;
    localparam int PERIOD  = 20;
    localparam int Q       = PERIOD / 4;
    localparam int MAXC    = (2 ** (CODE_W - 1)) - 1;
    localparam int MINC    = -(2 ** (CODE_W - 1));
    localparam int SAFE_ST = (2 ** (CODE_W - 2)) / Q;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     in_valid = 1'b0;
    logic signed [CODE_W-1:0] in_code = '0;
    logic                     dith_en = 1'b0;
    logic        [STEP_W-1:0] amp_step = '0;
    logic                     out_valid;
    logic signed [CODE_W-1:0] ch_a_code;
    logic signed [CODE_W-1:0] ch_b_code;

    int n_chk = 0;
    int n_bad = 0;
    int m_lvl = 0;
    int m_up  = 1;
    int last_a = 0;
    int last_b = 0;
    int hist [2*PERIOD];

    always #4 clk = ~clk;

    antiphase_dither_top #(
        .CODE_W(CODE_W), .STEP_W(STEP_W), .PERIOD(PERIOD)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_code(in_code),
        .dith_en(dith_en), .amp_step(amp_step), .out_valid(out_valid),
        .ch_a_code(ch_a_code), .ch_b_code(ch_b_code)
    );

    function automatic int clampc(input int v);
        if (v > MAXC) return MAXC;
        if (v < MINC) return MINC;
        return v;
    endfunction

    function automatic int halfc(input int v);
        return (v >= 0) ? v / 2 : -((-v + 1) / 2);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Present one cycle of input; check outputs one clock later (R1 latency).
    task automatic step_cycle(input bit v, input int x, input bit en, input int st,
                              input string req);
        int ea;
        int eb;
        in_valid = v;
        in_code  = CODE_W'(x);
        dith_en  = en;
        amp_step = STEP_W'(st);
        ea = last_a;
        eb = last_b;
        if (v && !en) begin
            ea = x;
            eb = x;
        end else if (v) begin
            ea = clampc(halfc(x) + m_lvl * st);
            eb = clampc(halfc(x) - m_lvl * st);
        end
        if (!en) begin
            m_lvl = 0;
            m_up  = 1;
        end else if (v) begin
            m_lvl = m_up ? m_lvl + 1 : m_lvl - 1;
            if (m_lvl == Q) m_up = 0;
            if (m_lvl == -Q) m_up = 1;
        end
        @(posedge clk);
        @(negedge clk);
        check({req, " R1 valid"}, int'(out_valid), int'(v));
        check({req, " lane A"}, int'(ch_a_code), ea);
        check({req, " lane B"}, int'(ch_b_code), eb);
        last_a = ea;
        last_b = eb;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset valid", int'(out_valid), 0);
        check("R1 reset A", int'(ch_a_code), 0);
        check("R1 reset B", int'(ch_b_code), 0);
        rst_n = 1'b1;

        // R2: bypass with dither off
        step_cycle(1, -1234, 0, 1000, "R2");
        step_cycle(1, MAXC, 0, 1000, "R2");
        step_cycle(1, MINC, 0, 1000, "R2");

        // R4: period and sequence at constant input; R6 sum
        for (int i = 0; i < 2 * PERIOD; i++) begin
            step_cycle(1, 101, 1, 700, "R4");
            hist[i] = int'(ch_a_code);
            check("R6 sum", int'(ch_a_code) + int'(ch_b_code), 2 * halfc(101));
        end
        for (int i = 0; i < PERIOD; i++) begin
            check("R4 period", hist[i + PERIOD], hist[i]);
        end
        check("R4 peak", hist[Q], halfc(101) + Q * 700);
        check("R4 trough", hist[3 * Q], halfc(101) - Q * 700);

        // R5: gaps hold outputs and phase
        step_cycle(1, 40, 1, 300, "R5");
        step_cycle(0, 9999, 1, 3000, "R5");
        step_cycle(0, -9999, 1, 3000, "R5");
        step_cycle(1, 40, 1, 300, "R5");

        // R8: drop enable, phase restarts at zero
        step_cycle(0, 0, 0, 0, "R8");
        step_cycle(1, 500, 1, 900, "R8");
        check("R8 restart", int'(ch_a_code), halfc(500));

        // R9: step change applies to the next sample
        step_cycle(1, 500, 1, 900, "R9");
        step_cycle(1, 500, 1, 50, "R9");

        // R7: clamping with oversized step
        step_cycle(0, 0, 0, 0, "R7");
        for (int i = 0; i < PERIOD; i++) begin
            step_cycle(1, MAXC, 1, 2 ** STEP_W - 1, "R7");
        end
        for (int i = 0; i < PERIOD; i++) begin
            step_cycle(1, MINC, 1, 2 ** STEP_W - 1, "R7");
        end

        // R3 R6: constrained random traffic
        for (int i = 0; i < 3000; i++) begin
            int x;
            int st;
            bit v;
            bit en;
            x  = int'($signed(CODE_W'($urandom)));
            st = int'($urandom % (SAFE_ST + 1));
            v  = ($urandom % 8) != 0;
            en = ($urandom % 50) != 0;
            step_cycle(v, x, en, st, "R3");
            if (v && en) begin
                check("R6 random sum", int'(ch_a_code) + int'(ch_b_code), 2 * halfc(x));
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule